// File: doc/BRIEF.md
# Multi-source reset sequencer

This block collects five reset requests (a power-up pulse, an external pin, a watchdog expiry, a network-interface request and a software request) and turns them into seven separate module resets: CPU, Ethernet front end, DMA, network interface, general control, memory controller and serial. Each request reaches its own subset of modules. Power-up, the external pin and the watchdog reset everything. The network-interface request spares the network interface and the memory controller. The software request touches only the Ethernet front end, DMA, general control and serial modules.

Once the CPU reset has been released, the block holds the CPU off the bus for a fixed window of `HOLD_CYCLES` clocks (512 by default). During that window it flags that the whole memory map decodes to chip select 0. Any request that resets the CPU during the window starts the count again. A sticky cause register records which sources have fired since it was last read, and a one-cycle read strobe clears it.

Top module: `rst_seq`

## Requirements
- R1: `por_i` high sets all seven reset outputs, `fetch_hold_o` and `cs0_only_o` at once, without waiting for a clock. When it falls, and no other source is active, the reset outputs clear on the first rising edge.
- R2: `ext_rst_n_i` low sets all seven reset outputs at once. After the pin returns high it passes through a two-flop synchronizer, so the outputs clear on the third rising edge after the pin rises.
- R3: `wdog_req_i` sampled high at a rising edge drives all seven reset outputs high after that edge.
- R4: `net_req_i` sampled high, with the watchdog request low, drives the CPU, Ethernet, DMA, general and serial resets high after that edge, while the network-interface and memory resets stay low.
- R5: `sw_req_i` sampled high, with the other two synchronous requests low, drives only the Ethernet, DMA, general and serial resets. The CPU, network-interface and memory resets stay low.
- R6: `fetch_hold_o` is high whenever `rst_cpu_o` is high. It then stays high for exactly `HOLD_CYCLES` rising edges counted from the edge that clears `rst_cpu_o`, and falls on the last of them.
- R7: `cs0_only_o` is high over exactly the same window as `fetch_hold_o`.
- R8: A watchdog or network-interface request arriving during the hold window restarts the full count from its own release. A software request does not change the window.
- R9: `cause_o` is sticky. Bit 0 is power-up, bit 1 the external pin, bit 2 the watchdog, bit 3 the network interface and bit 4 software. A source sets its bit at each rising edge where it is active. Power-up sets the register to 5'b00001 at once.
- R10: A one-cycle `cause_rd_i` pulse clears `cause_o` at the next rising edge. The exception is the bits of sources active in that same cycle, which stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-up reset pulse, active high, asynchronous |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| wdog_req_i | input | 1 | Watchdog reset request, synchronous level |
| net_req_i | input | 1 | Network-interface reset request, synchronous level |
| sw_req_i | input | 1 | Software reset request, synchronous level |
| cause_rd_i | input | 1 | Read strobe that clears the cause register |
| rst_cpu_o | output | 1 | CPU reset, active high |
| rst_eth_o | output | 1 | Ethernet front-end reset |
| rst_dma_o | output | 1 | DMA reset |
| rst_net_o | output | 1 | Network-interface reset |
| rst_gen_o | output | 1 | General control reset |
| rst_mem_o | output | 1 | Memory controller reset |
| rst_ser_o | output | 1 | Serial reset |
| fetch_hold_o | output | 1 | CPU fetch hold, covering the reset and the post-release window |
| cs0_only_o | output | 1 | Whole memory map decodes to chip select 0 |
| cause_o | output | 5 | Sticky record of the reset sources |

## Verification
The bench drives all eight combinations of the three synchronous requests and compares the seven resets against each source's subset. These combinations separate a priority mistake (a weaker source masking the watchdog) from a wrong subset wiring. The two asynchronous sources are checked between clock edges, which tells asynchronous assertion apart from registered assertion. Their release edges are counted, which catches a missing or extra synchronizer stage. The hold window is measured from its start: plainly, with a software pulse inside it, and with a network pulse inside it. This tells an off-by-one count apart from a restart applied to the wrong source.

// File: rtl/rst_seq.sv
module rst_seq #(
  parameter int HOLD_CYCLES = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       ext_rst_n_i,
  input  logic       wdog_req_i,
  input  logic       net_req_i,
  input  logic       sw_req_i,
  input  logic       cause_rd_i,
  output logic       rst_cpu_o,
  output logic       rst_eth_o,
  output logic       rst_dma_o,
  output logic       rst_net_o,
  output logic       rst_gen_o,
  output logic       rst_mem_o,
  output logic       rst_ser_o,
  output logic       fetch_hold_o,
  output logic       cs0_only_o,
  output logic [4:0] cause_o
);
  localparam int CW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [SYNC_STAGES-1:0] ext_sync;
  logic                   ext_ok;
  logic                   hard;
  logic                   cpu_req;
  logic                   part_req;
  logic [CW-1:0]          cnt;
  logic                   hold;
  logic [4:0]             cause;

  always_ff @(posedge clk or negedge ext_rst_n_i)
    if (!ext_rst_n_i) ext_sync <= '0;
    else              ext_sync <= {ext_sync[SYNC_STAGES-2:0], 1'b1};

  assign ext_ok   = ext_sync[SYNC_STAGES-1];
  assign hard     = por_i | ~ext_ok;
  assign cpu_req  = wdog_req_i | net_req_i;
  assign part_req = cpu_req | sw_req_i;

  always_ff @(posedge clk or posedge hard)
    if (hard) begin
      rst_cpu_o <= 1'b1;
      rst_eth_o <= 1'b1;
      rst_dma_o <= 1'b1;
      rst_net_o <= 1'b1;
      rst_gen_o <= 1'b1;
      rst_mem_o <= 1'b1;
      rst_ser_o <= 1'b1;
    end else begin
      rst_cpu_o <= cpu_req;
      rst_eth_o <= part_req;
      rst_dma_o <= part_req;
      rst_net_o <= wdog_req_i;
      rst_gen_o <= part_req;
      rst_mem_o <= wdog_req_i;
      rst_ser_o <= part_req;
    end

  always_ff @(posedge clk or posedge hard)
    if (hard) begin
      cnt  <= '0;
      hold <= 1'b1;
    end else if (cpu_req || rst_cpu_o) begin
      cnt  <= '0;
      hold <= 1'b1;
    end else if (hold) begin
      if (cnt == LAST) hold <= 1'b0;
      else             cnt  <= cnt + 1'b1;
    end

  assign fetch_hold_o = hold;
  assign cs0_only_o   = hold;

  always_ff @(posedge clk or posedge por_i)
    if (por_i) cause <= 5'b00001;
    else       cause <= (cause_rd_i ? 5'b0 : cause)
                        | {sw_req_i, net_req_i, wdog_req_i, ~ext_ok, 1'b0};

  assign cause_o = cause;
endmodule

module rst_seq_chk (
  input logic       clk,
  input logic       hard,
  input logic       wdog_req_i,
  input logic       net_req_i,
  input logic       sw_req_i,
  input logic       cause_rd_i,
  input logic       rst_cpu_o,
  input logic       rst_eth_o,
  input logic       rst_dma_o,
  input logic       rst_net_o,
  input logic       rst_gen_o,
  input logic       rst_mem_o,
  input logic       rst_ser_o,
  input logic       fetch_hold_o,
  input logic       cs0_only_o,
  input logic [4:0] cause_o
);
  assert_wdog_all_R3: assert property (@(posedge clk) disable iff (hard)
    wdog_req_i |=> (rst_cpu_o && rst_eth_o && rst_dma_o && rst_net_o
                    && rst_gen_o && rst_mem_o && rst_ser_o));

  assert_net_subset_R4: assert property (@(posedge clk) disable iff (hard)
    (net_req_i && !wdog_req_i) |=> (rst_cpu_o && rst_eth_o && rst_dma_o
                    && rst_gen_o && rst_ser_o && !rst_net_o && !rst_mem_o));

  assert_sw_subset_R5: assert property (@(posedge clk) disable iff (hard)
    (sw_req_i && !net_req_i && !wdog_req_i) |=> (!rst_cpu_o && rst_eth_o
                    && rst_dma_o && rst_gen_o && rst_ser_o && !rst_net_o && !rst_mem_o));

  assert_hold_cover_R6: assert property (@(posedge clk) disable iff (hard)
    rst_cpu_o |-> (fetch_hold_o && cs0_only_o));

  assert_hold_after_release_R6: assert property (@(posedge clk) disable iff (hard)
    $fell(fetch_hold_o) |-> (!rst_cpu_o && $past(!rst_cpu_o)));

  assert_restart_R8: assert property (@(posedge clk) disable iff (hard)
    net_req_i |=> (fetch_hold_o && rst_cpu_o));

  assert_clear_R10: assert property (@(posedge clk) disable iff (hard)
    (cause_rd_i && !wdog_req_i && !net_req_i && !sw_req_i) |=> (cause_o == 5'b0));
endmodule

bind rst_seq rst_seq_chk u_chk (
  .clk(clk), .hard(hard), .wdog_req_i(wdog_req_i), .net_req_i(net_req_i),
  .sw_req_i(sw_req_i), .cause_rd_i(cause_rd_i), .rst_cpu_o(rst_cpu_o),
  .rst_eth_o(rst_eth_o), .rst_dma_o(rst_dma_o), .rst_net_o(rst_net_o),
  .rst_gen_o(rst_gen_o), .rst_mem_o(rst_mem_o), .rst_ser_o(rst_ser_o),
  .fetch_hold_o(fetch_hold_o), .cs0_only_o(cs0_only_o), .cause_o(cause_o)
);

// File: tb/tb_rst_seq.sv
module tb_rst_seq;
  localparam int HOLD = 512;

  logic clk = 1'b0;
  logic por_i = 1'b0, ext_rst_n_i = 1'b1;
  logic wdog_req_i = 1'b0, net_req_i = 1'b0, sw_req_i = 1'b0, cause_rd_i = 1'b0;
  logic rst_cpu_o, rst_eth_o, rst_dma_o, rst_net_o, rst_gen_o, rst_mem_o, rst_ser_o;
  logic fetch_hold_o, cs0_only_o;
  logic [4:0] cause_o;
  logic [6:0] rv;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  rst_seq #(.HOLD_CYCLES(HOLD)) dut (
    .clk(clk), .por_i(por_i), .ext_rst_n_i(ext_rst_n_i), .wdog_req_i(wdog_req_i),
    .net_req_i(net_req_i), .sw_req_i(sw_req_i), .cause_rd_i(cause_rd_i),
    .rst_cpu_o(rst_cpu_o), .rst_eth_o(rst_eth_o), .rst_dma_o(rst_dma_o),
    .rst_net_o(rst_net_o), .rst_gen_o(rst_gen_o), .rst_mem_o(rst_mem_o),
    .rst_ser_o(rst_ser_o), .fetch_hold_o(fetch_hold_o), .cs0_only_o(cs0_only_o),
    .cause_o(cause_o));

  assign rv = {rst_cpu_o, rst_eth_o, rst_dma_o, rst_net_o, rst_gen_o, rst_mem_o, rst_ser_o};

  // {wdog, net, sw} then expected {cpu, eth, dma, net, gen, mem, ser}
  localparam logic [9:0] VECS [9] = '{
    {3'b001, 7'h35}, {3'b000, 7'h00}, {3'b010, 7'h75}, {3'b011, 7'h75},
    {3'b100, 7'h7F}, {3'b101, 7'h7F}, {3'b110, 7'h7F}, {3'b111, 7'h7F},
    {3'b000, 7'h00}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_hold(output int n);
    n = 0;
    while (fetch_hold_o && n < 4000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic report;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    int n;
    #1 por_i = 1'b1;
    #1;
    chk(rv == 7'h7F, "R1 async power-up", rv, 7'h7F);
    chk(fetch_hold_o && cs0_only_o, "R7 window in reset", {fetch_hold_o, cs0_only_o}, 3);
    chk(cause_o == 5'b00001, "R9 power-up cause", cause_o, 1);
    repeat (4) @(negedge clk);
    por_i = 1'b0;
    @(negedge clk);
    chk(rv == 7'h00, "R1 release", rv, 0);
    chk(fetch_hold_o == 1'b1, "R6 hold after release", fetch_hold_o, 1);
    cause_rd_i = 1'b1;
    chk(cause_o == 5'b00001, "R9 cause before read", cause_o, 1);
    @(negedge clk);
    cause_rd_i = 1'b0;
    chk(cause_o == 5'b0, "R10 read clears", cause_o, 0);
    repeat (510) @(negedge clk);
    chk(fetch_hold_o && cs0_only_o, "R6 hold at 511", fetch_hold_o, 1);
    @(negedge clk);
    chk(!fetch_hold_o && !cs0_only_o, "R6 R7 hold ends at 512", {fetch_hold_o, cs0_only_o}, 0);

    ext_rst_n_i = 1'b0;
    #1;
    chk(rv == 7'h7F, "R2 async external", rv, 7'h7F);
    chk(fetch_hold_o == 1'b1, "R6 hold during external", fetch_hold_o, 1);
    @(negedge clk);
    @(negedge clk);
    ext_rst_n_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(rv == 7'h7F, "R2 held two edges", rv, 7'h7F);
    @(negedge clk);
    chk(rv == 7'h00, "R2 release third edge", rv, 0);
    chk(cause_o == 5'b00010, "R9 external cause", cause_o, 2);
    cause_rd_i = 1'b1;
    @(negedge clk);
    cause_rd_i = 1'b0;
    chk(cause_o == 5'b0, "R10 clear after external", cause_o, 0);

    for (int i = 0; i < 9; i++) begin
      {wdog_req_i, net_req_i, sw_req_i} = VECS[i][9:7];
      @(negedge clk);
      chk(rv == VECS[i][6:0], $sformatf("R3 R4 R5 vector %0d", i), rv, VECS[i][6:0]);
    end
    chk(cause_o == 5'b11100, "R9 sticky sources", cause_o, 5'h1C);
    chk(fetch_hold_o == 1'b1, "R6 hold from vectors", fetch_hold_o, 1);

    repeat (100) @(negedge clk);
    sw_req_i = 1'b1;
    cause_rd_i = 1'b1;
    @(negedge clk);
    sw_req_i = 1'b0;
    cause_rd_i = 1'b0;
    chk(rst_eth_o && !rst_cpu_o, "R5 sw in window", rv, 7'h35);
    chk(cause_o == 5'b10000, "R10 active source kept", cause_o, 5'h10);
    wait_hold(n);
    chk(n == HOLD - 101, "R8 sw leaves window", n, HOLD - 101);

    net_req_i = 1'b1;
    @(negedge clk);
    net_req_i = 1'b0;
    @(negedge clk);
    repeat (300) @(negedge clk);
    net_req_i = 1'b1;
    @(negedge clk);
    net_req_i = 1'b0;
    chk(rst_cpu_o && fetch_hold_o, "R8 net in window", {rst_cpu_o, fetch_hold_o}, 3);
    @(negedge clk);
    wait_hold(n);
    chk(n == HOLD, "R8 restart full count", n, HOLD);

    wdog_req_i = 1'b1;
    @(negedge clk);
    wdog_req_i = 1'b0;
    chk(rv == 7'h7F, "R3 watchdog alone", rv, 7'h7F);
    @(negedge clk);
    por_i = 1'b1;
    #1;
    chk(cause_o == 5'b00001, "R9 power-up overrides", cause_o, 1);
    chk(rv == 7'h7F, "R1 async mid-run", rv, 7'h7F);
    @(negedge clk);
    por_i = 1'b0;
    @(negedge clk);
    chk(rv == 7'h00, "R1 release mid-run", rv, 0);
    report();
  end
endmodule